// File: doc/BRIEF.md
# Dual-Slot Peripheral DMA Channel

This block is one channel of a memory-to-peripheral DMA engine. It has two buffer descriptor slots, and each slot holds a byte count and a start address. The channel always drains the slots in strict alternation. While one slot is being transferred, software can fill the other one, so the peripheral sees a continuous stream of buffers without waiting for software.

Each transfer beat starts when the peripheral raises its request. The channel then issues one read on a simple memory request port, waits for the response, and hands the data to the peripheral with a one-cycle acknowledge. A four-state occupancy machine tracks the channel:

- idle
- stall: enabled, but nothing loaded
- on: one buffer loaded
- next: two buffers loaded

Three interrupt sources, each with its own enable, drive a single interrupt line:

- stall: the channel ran out of buffers
- next-free-buffer: a slot has been released
- error: the memory port reported an error

The registers sit on a word-addressed bus. Writes take effect at the clock edge, and reads are combinational.

Top module: `dsdma_chan`

## Requirements
- R1: After reset the state field reads idle (0), the interrupt line, `mem_req` and `per_ack` are low, and every register reads zero.
- R2: Word 3 bits [5:4] give the state: 0 idle, 1 stall, 2 on, 3 next. Setting the enable bit (control bit 4, word 0) in idle moves the channel to stall on the following clock edge. The state reads 2 with one slot loaded and 3 with both slots loaded. Idle never shows `mem_req`.
- R3: Slot 0 is at words 8 (count) and 9 (address). Slot 1 is at words 12 (count) and 13 (address). Only one slot is accepted at a time:
  - After an enable from idle, the accepted slot is slot 0.
  - When the active slot is empty, the active slot is accepted.
  - When the active slot is loaded, the other slot is accepted.
  - When both slots are loaded, neither is accepted.
  Writing the address of the accepted slot loads it. A write to any other slot register leaves its readback unchanged.
- R4: A beat starts when all of these hold: the active slot is loaded, its remaining count is non-zero, `per_req` is high and no beat is in flight. The channel then holds `mem_req` with a stable `mem_addr` until `mem_ack`. On the next cycle it pulses `per_ack` for one cycle with `per_data` equal to the read data. The address then advances by BEAT_BYTES, and the remaining count falls by BEAT_BYTES, floored at zero.
- R5: Word 5 reads the bytes left in the active buffer. It is loaded from the slot count when the slot becomes active.
- R6: When the remaining count is zero and no beat is in flight, the active buffer finishes on the next edge that has no slot-register write. If the other slot is loaded, the channel switches to it, the state drops from next to on, and the next-free-buffer flag (word 1 bit 1) is set.
- R7: A finish with the other slot empty moves the channel to stall and sets the stall flag (word 1 bit 0).
- R8: An accepted slot load clears the stall and next-free-buffer flags. Writing 1 to word 1 bit 3 clears the error flag, and any other write to word 1 leaves the flags unchanged.
- R9: `irq` is high exactly when at least one set flag has its enable set. The enables are control bit 0 (stall), bit 1 (next-free-buffer) and bit 3 (error).
- R10: A `mem_err` during a beat stops the transfer. It discards both slots, sets the error flag (word 1 bit 3), and puts the channel in stall. No `per_ack` follows.
- R11: While the enable bit is clear, slot writes are ignored. A channel that is not idle keeps transferring until both loaded buffers are drained. It then shows stall for one cycle and returns to idle.
- R12: Word 2 bits [3:0] hold the peripheral port selection, which drives `port_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Memory read data valid |
| mem_err | input | 1 | Memory error response |
| mem_rdata | input | DATA_W | Memory read data |
| per_req | input | 1 | Peripheral asks for a beat |
| per_ack | output | 1 | One-cycle beat delivery to the peripheral |
| per_data | output | DATA_W | Beat data for the peripheral |
| port_sel | output | 4 | Selected peripheral port |
| irq | output | 1 | Channel interrupt |

## Verification
The bench loads the slots out of turn and also while both slots are full. A design that ignored the alternation would overwrite a live descriptor or start from the wrong slot. A buffer count that is not a multiple of the beat size checks the floored countdown; a wrong countdown would wrap and run away. An error is injected while both slots are loaded, which would expose a channel that kept the second slot or acknowledged the failed beat. A disable with two loaded buffers is watched for a full drain followed by exactly one stall cycle; a design that dropped the pending buffer or skipped stall would be caught.

// File: rtl/dsdma_chan.sv
`timescale 1ns/1ps
module dsdma_chan #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_data,
  output logic [3:0]        port_sel,
  output logic              irq
);
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(BEAT_BYTES);

  logic [4:0]        ctl;
  logic              f_st, f_nf, f_er;
  logic              chan_on, act, busy;
  logic [1:0]        ld;
  logic [1:0]        chan_st;
  logic [CNT_W-1:0]  cnt  [2];
  logic [ADDR_W-1:0] base [2];
  logic [CNT_W-1:0]  rem;
  logic [ADDR_W-1:0] cur;

  wire is_slot  = reg_we && reg_addr[3] && !reg_addr[1];
  wire wsl      = reg_addr[2];
  wire tgt      = ld[act] ? !act : act;
  wire w_ok     = is_slot && ctl[4] && chan_on && !(&ld) && (wsl == tgt);
  wire w_base   = w_ok && reg_addr[0];
  wire w_cnt    = w_ok && !reg_addr[0];
  wire done     = chan_on && ld[act] && (rem == '0) && !busy && !is_slot;
  wire start    = chan_on && ld[act] && (rem != '0) && !busy && per_req;
  wire beat_ok  = busy && mem_ack && !mem_err;
  wire beat_bad = busy && mem_err;

  assign chan_st  = !chan_on ? 2'd0 : (&ld) ? 2'd3 : (|ld) ? 2'd2 : 2'd1;
  assign mem_req  = busy;
  assign mem_addr = cur;
  assign irq      = (f_st & ctl[0]) | (f_nf & ctl[1]) | (f_er & ctl[3]);

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = 32'(ctl);
      4'h1:    reg_rdata = {28'd0, f_er, 1'b0, f_nf, f_st};
      4'h2:    reg_rdata = {28'd0, port_sel};
      4'h3:    reg_rdata = {26'd0, chan_st, 4'd0};
      4'h5:    reg_rdata = 32'(rem);
      4'h8:    reg_rdata = 32'(cnt[0]);
      4'h9:    reg_rdata = 32'(base[0]);
      4'hC:    reg_rdata = 32'(cnt[1]);
      4'hD:    reg_rdata = 32'(base[1]);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; port_sel <= '0;
      f_st <= 1'b0; f_nf <= 1'b0; f_er <= 1'b0;
      chan_on <= 1'b0; act <= 1'b0; busy <= 1'b0; ld <= '0;
      cnt[0] <= '0; cnt[1] <= '0; base[0] <= '0; base[1] <= '0;
      rem <= '0; cur <= '0;
      per_ack <= 1'b0; per_data <= '0;
    end else begin
      per_ack <= beat_ok;
      if (beat_ok) per_data <= mem_rdata;
      if (reg_we && reg_addr == 4'h0) ctl <= {reg_wdata[4:3], 1'b0, reg_wdata[1:0]};
      if (reg_we && reg_addr == 4'h2) port_sel <= reg_wdata[3:0];
      if (reg_we && reg_addr == 4'h1 && reg_wdata[3]) f_er <= 1'b0;

      if (!chan_on && ctl[4]) begin
        chan_on <= 1'b1;
        act     <= 1'b0;
        ld      <= '0;
      end else if (chan_on && !ctl[4] && ld == '0 && !busy) begin
        chan_on <= 1'b0;
      end

      if (w_cnt) cnt[wsl] <= reg_wdata[CNT_W-1:0];
      if (w_base) begin
        base[wsl] <= reg_wdata[ADDR_W-1:0];
        ld[wsl]   <= 1'b1;
        f_st      <= 1'b0;
        f_nf      <= 1'b0;
        if (wsl == act) begin
          rem <= cnt[wsl];
          cur <= reg_wdata[ADDR_W-1:0];
        end
      end

      if (start) busy <= 1'b1;
      if (beat_ok) begin
        busy <= 1'b0;
        rem  <= (rem > CSTEP) ? rem - CSTEP : '0;
        cur  <= cur + ASTEP;
      end

      if (done) begin
        ld[act] <= 1'b0;
        act     <= !act;
        if (ld[!act]) begin
          f_nf <= 1'b1;
          rem  <= cnt[!act];
          cur  <= base[!act];
        end else begin
          f_st <= 1'b1;
        end
      end

      if (beat_bad) begin
        busy <= 1'b0;
        ld   <= '0;
        rem  <= '0;
        f_er <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsdma_chan_chk.sv
`timescale 1ns/1ps
module dsdma_chan_chk #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              per_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        chan_st
);
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_err |=> per_ack);                                   // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);                                                         // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr));             // R4
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_err |=> !per_ack && chan_st == 2'd1);                           // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chan_st == 2'd0 |-> !mem_req);                                                 // R2
  AST_NEXT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_st == 2'd3 && !(mem_req && mem_err) |=> chan_st[1]);                      // R6
  AST_IDLE_VIA_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    chan_st[1] |=> chan_st != 2'd0);                                               // R11
endmodule

bind dsdma_chan dsdma_chan_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_err(mem_err), .per_ack(per_ack), .mem_addr(mem_addr), .chan_st(chan_st)
);

// File: tb/dsdma_chan_tb_top.sv
`timescale 1ns/1ps
module dsdma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic [31:0] per_data;
  logic [3:0]  port_sel;
  logic        irq;

  int n_chk = 0, n_fail = 0, beats = 0;
  int err_tok = 0, err_used = 0, wait_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dsdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .per_req(per_req), .per_ack(per_ack),
    .per_data(per_data), .port_sel(port_sel), .irq(irq)
  );

  // memory responder: one cycle of wait, then data or an injected error
  always @(negedge clk) begin
    if (mem_ack || mem_err) begin
      mem_ack = 1'b0; mem_err = 1'b0; wait_n = 0;
    end else if (mem_req) begin
      if (wait_n >= 1) begin
        if (err_tok != err_used) begin
          mem_err = 1'b1; err_used++;
        end else begin
          mem_ack = 1'b1; mem_rdata = mem_addr ^ 32'h5A5A_0000;
        end
      end else wait_n++;
    end
  end

  always @(negedge clk) if (per_ack) beats++;

  // behavioural reference model
  bit          m_on, m_act, m_busy, m_pack, m_st, m_nf, m_er;
  logic [4:0]  m_ctl;
  logic [3:0]  m_port;
  logic [31:0] m_pdata, m_addr;
  int          m_rem;
  int          m_scnt [2];
  int          q_c[$];
  logic [31:0] q_b[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_act = 0; m_busy = 0; m_pack = 0; m_st = 0; m_nf = 0; m_er = 0;
      m_ctl = '0; m_port = '0; m_pdata = '0; m_addr = '0; m_rem = 0;
      m_scnt[0] = 0; m_scnt[1] = 0; q_c.delete(); q_b.delete();
    end else begin
      bit slotw, acc, fin, go, gd, bad, ws, exp_s;
      int n;
      n     = q_c.size();
      slotw = reg_we && (reg_addr == 8 || reg_addr == 9 || reg_addr == 12 || reg_addr == 13);
      ws    = (reg_addr >= 12);
      exp_s = (n == 0) ? m_act : !m_act;
      acc   = slotw && m_ctl[4] && m_on && n < 2 && ws == exp_s;
      fin   = m_on && n > 0 && m_rem == 0 && !m_busy && !slotw;
      go    = m_on && n > 0 && m_rem != 0 && !m_busy && per_req;
      gd    = m_busy && mem_ack && !mem_err;
      bad   = m_busy && mem_err;

      m_pack = gd;
      if (gd) m_pdata = mem_rdata;
      if (!m_on && m_ctl[4]) begin m_on = 1; m_act = 0; end
      else if (m_on && !m_ctl[4] && n == 0 && !m_busy) m_on = 0;
      if (reg_we && reg_addr == 0) m_ctl = {reg_wdata[4:3], 1'b0, reg_wdata[1:0]};
      if (reg_we && reg_addr == 2) m_port = reg_wdata[3:0];
      if (reg_we && reg_addr == 1 && reg_wdata[3]) m_er = 0;
      if (acc) begin
        if (!reg_addr[0]) m_scnt[ws] = int'(reg_wdata[15:0]);
        else begin
          q_c.push_back(m_scnt[ws]); q_b.push_back(reg_wdata);
          m_st = 0; m_nf = 0;
          if (n == 0) begin m_rem = m_scnt[ws]; m_addr = reg_wdata; end
        end
      end
      if (go) m_busy = 1;
      if (gd) begin
        m_busy = 0;
        m_rem  = (m_rem > 4) ? m_rem - 4 : 0;
        m_addr = m_addr + 32'd4;
      end
      if (fin) begin
        void'(q_c.pop_front()); void'(q_b.pop_front());
        m_act = !m_act;
        if (q_c.size() > 0) begin m_nf = 1; m_rem = q_c[0]; m_addr = q_b[0]; end
        else m_st = 1;
      end
      if (bad) begin
        m_busy = 0; q_c.delete(); q_b.delete(); m_rem = 0; m_er = 1;
      end
    end
  end

  function automatic logic [31:0] m_state();
    return m_on ? 32'((q_c.size() + 1) << 4) : 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison of the ports against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic m_irq;
      m_irq = (m_st & m_ctl[0]) | (m_nf & m_ctl[1]) | (m_er & m_ctl[3]);
      check("R4 mem_req", 32'(mem_req), 32'(m_busy));
      if (m_busy) check("R4 mem_addr", mem_addr, m_addr);
      check("R4 per_ack", 32'(per_ack), 32'(m_pack));
      if (m_pack) check("R4 per_data", per_data, m_pdata);
      check("R9 irq", 32'(irq), 32'(m_irq));
      check("R12 port_sel", 32'(port_sel), 32'(m_port));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); reg_addr = a[3:0]; #1; v = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int b0;
    bit saw_stall;
    cyc(3); rst_n = 1'b1; cyc(2);

    rd(3, v); check("R1 state", v, 32'h0);
    rd(0, v); check("R1 control", v, 32'h0);
    rd(5, v); check("R1 remaining", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 mem_req", 32'(mem_req), 32'h0);
    check("R1 per_ack", 32'(per_ack), 32'h0);

    wr(9, 32'h100); rd(9, v); check("R11 idle load ignored", v, 32'h0);
    wr(0, 32'h1B); cyc(1);
    rd(3, v); check("R2 stall after enable", v, 32'h10);
    wr(12, 8); wr(13, 32'h2000);
    rd(13, v); check("R3 out-of-turn slot ignored", v, 32'h0);
    rd(3, v); check("R3 state unchanged", v, 32'h10);
    wr(8, 16); wr(9, 32'h1000);
    rd(3, v); check("R2 on", v, 32'h20);
    rd(5, v); check("R5 remaining loaded", v, 32'd16);
    wr(12, 8); wr(13, 32'h2000);
    rd(3, v); check("R2 next", v, 32'h30);
    wr(9, 32'h9999); rd(9, v); check("R3 full slots ignore write", v, 32'h1000);

    b0 = beats; per_req = 1'b1;
    for (int i = 0; i < 100; i++) begin rd(3, v); if (v == 32'h20) break; end
    check("R6 next to on", v, 32'h20);
    rd(1, v); check("R6 next-free flag", v & 32'h2, 32'h2);
    rd(5, v); check("R5 remaining after switch", v, 32'(m_rem));
    cyc(40);
    rd(3, v); check("R7 stall after drain", v, 32'h10);
    rd(1, v); check("R7 stall flag", v, 32'h3);
    check("R4 beat count", 32'(beats - b0), 32'd6);
    check("R9 irq raised", 32'(irq), 32'h1);
    wr(0, 32'h10); check("R9 irq masked", 32'(irq), 32'h0);
    wr(0, 32'h1B); check("R9 irq unmasked", 32'(irq), 32'h1);
    wr(1, 32'h8); rd(1, v); check("R8 error clear keeps others", v, 32'h3);

    b0 = beats; wr(8, 6); wr(9, 32'h3000);
    rd(1, v); check("R8 load clears flags", v, 32'h0);
    cyc(30);
    check("R4 floored countdown", 32'(beats - b0), 32'd2);
    rd(5, v); check("R5 remaining zero", v, 32'h0);
    rd(3, v); check("R7 stall again", v, 32'h10);

    per_req = 1'b0;
    wr(12, 32); wr(13, 32'h4000); wr(8, 8); wr(9, 32'h5000);
    rd(3, v); check("R2 next before error", v, 32'h30);
    err_tok++; b0 = beats; per_req = 1'b1; cyc(20);
    rd(3, v); check("R10 stall after error", v, 32'h10);
    rd(1, v); check("R10 error flag", v, 32'h8);
    check("R10 no beat delivered", 32'(beats - b0), 32'd0);
    check("R9 error irq", 32'(irq), 32'h1);
    wr(1, 32'h8); rd(1, v); check("R8 error cleared", v, 32'h0);
    check("R9 irq low", 32'(irq), 32'h0);

    per_req = 1'b0;
    wr(12, 8); wr(13, 32'h6000); wr(8, 4); wr(9, 32'h7000);
    rd(3, v); check("R3 alternation after error", v, 32'h30);
    wr(0, 32'h0B); b0 = beats; per_req = 1'b1; saw_stall = 0;
    for (int i = 0; i < 200; i++) begin
      rd(3, v);
      if (v == 32'h10) saw_stall = 1;
      if (v == 32'h0) break;
    end
    check("R11 idle reached", v, 32'h0);
    check("R11 passed stall", 32'(saw_stall), 32'h1);
    check("R11 drained both", 32'(beats - b0), 32'd3);
    wr(9, 32'hABC0); rd(9, v); check("R11 load ignored when off", v, 32'h7000);

    per_req = 1'b0;
    wr(0, 32'h10); cyc(1);
    rd(3, v); check("R2 re-enable stall", v, 32'h10);
    wr(12, 4); wr(13, 32'hB000);
    rd(3, v); check("R3 slot 1 refused first", v, 32'h10);
    wr(8, 4); wr(9, 32'hC000);
    rd(3, v); check("R3 slot 0 first", v, 32'h20);
    per_req = 1'b1; cyc(12);
    rd(3, v); check("R7 stall end", v, 32'h10);

    wr(2, 5); check("R12 port output", 32'(port_sel), 32'h5);
    rd(2, v); check("R12 port readback", v, 32'h5);

    done = 1;
    report();
    $finish;
  end
endmodule